// File: doc/BRIEF.md
# Partially Decoded Two-Bank Memory

This block places a small byte-wide memory behind a 16-bit processor address bus. Storage is split into two banks of 256 bytes each. The top address bit chooses the bank: one bank is enabled while that bit is low and the other while it is high, so exactly one bank answers any access.

The seven middle address bits take no part in decoding. Each stored byte therefore appears at 128 processor addresses. A flag marks any address whose middle bits are nonzero, so a testbench can confirm that such an address reaches the same storage as its base address.

The bus strobes are active low: one chip select, one read strobe and one write strobe. Writes commit on the rising clock edge. Read data is combinational and is forced to zero when no read is in progress. If a cycle asserts both strobes while the block is selected, nothing is accessed and an error flag pulses.

Top module: `aliased_bank_mem`

## Requirements
- R1: The location inside a bank comes from addr_i[7:0]. addr_i[15]=0 picks bank 0 and addr_i[15]=1 picks bank 1. Each bank holds 256 bytes.
- R2: While the block is selected, exactly one bank is enabled. Both banks keep separate contents, for 512 distinct byte locations in total.
- R3: addr_i[14:8] has no effect on which location is read or written. A write through any such alias is visible at the base address.
- R4: ghost_o is high, combinationally, whenever any bit of addr_i[14:8] is 1, and low otherwise.
- R5: A read occurs only when cs_n_i=0, rd_n_i=0 and wr_n_i=1. rdata_o then shows the addressed byte in the same cycle. In every other case rdata_o is 8'h00.
- R6: A write occurs only when cs_n_i=0, wr_n_i=0 and rd_n_i=1. wdata_i replaces the addressed byte at the next rising clock edge. A write strobe without chip select changes nothing.
- R7: Reading a location leaves its contents unchanged.
- R8: In a cycle where cs_n_i=0, rd_n_i=0 and wr_n_i=0, no write occurs and rdata_o is 8'h00. conflict_o is high for the single following cycle. Both strobes low with cs_n_i=1 raises no flag.
- R9: While rst_n is low and after its release, conflict_o is 0 until a conflicting cycle occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Processor address |
| wdata_i | input | 8 | Write data |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| rdata_o | output | 8 | Read data, zero when no read is active |
| ghost_o | output | 1 | High when address bits 14..8 are nonzero |
| conflict_o | output | 1 | One-cycle pulse after a read-and-write clash |

## Verification
All 512 locations are first filled so that bank 1 holds the complement of bank 0 at every offset. Reading back every location shows that the top address bit reaches separate storage and that the low byte selects the location. Reads and writes through several middle-bit patterns (single low bit, single high bit, all ones, alternating) show whether any middle bit leaks into decoding; the ghost flag is checked on every cycle. Strobe combinations that must do nothing are followed by a read of the same location: deselected reads and writes, repeated reads, and clashes with and without chip select. These reads tell a gating fault apart from a storage fault.

// File: rtl/ghostmem_pkg.sv
`timescale 1ns/1ps
package ghostmem_pkg;
   // Kind of bus cycle seen this clock
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_CLASH = 2'd3
   } acc_kind_e;

   function automatic acc_kind_e classify(input logic cs_n, input logic rd_n, input logic wr_n);
      if (cs_n)                 return ACC_IDLE;
      else if (!rd_n && !wr_n)  return ACC_CLASH;
      else if (!rd_n)           return ACC_READ;
      else if (!wr_n)           return ACC_WRITE;
      else                      return ACC_IDLE;
   endfunction
endpackage

// File: rtl/bank_select_decode.sv
`timescale 1ns/1ps
module bank_select_decode #(
   parameter int CPU_AW  = 16,
   parameter int SEL_BIT = 15,
   parameter int NBANK   = 2
) (
   input  logic [CPU_AW-1:0] addr,
   output logic [NBANK-1:0]  bank_en
);
   generate
      if (NBANK != 2) begin : g_bad_nbank
         $error("bank_select_decode: exactly two banks are supported");
      end
      if (SEL_BIT >= CPU_AW) begin : g_bad_sel
         $error("bank_select_decode: select bit outside address");
      end
   endgenerate

   // one bank sees the select bit as active-low, the other as active-high
   generate
      for (genvar g = 0; g < NBANK; g++) begin : g_pol
         if (g == 0) begin : g_low
            assign bank_en[g] = ~addr[SEL_BIT];
         end else begin : g_high
            assign bank_en[g] = addr[SEL_BIT];
         end
      end
   endgenerate
endmodule

// File: rtl/bank_store.sv
`timescale 1ns/1ps
module bank_store #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          rd,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   generate
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("bank_store: AW out of range");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en && wr) mem[addr] <= wdata;
   end

   assign rdata = (en && rd) ? mem[addr] : '0;

   // R6: an enabled write lands at the addressed word
   a_r6_write_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wr) |=> (mem[$past(addr)] == $past(wdata)));

   // R7: a read does not disturb the word it returned
   a_r7_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (en && rd && !wr) |=> (mem[$past(addr)] == $past(rdata)));
endmodule

// File: rtl/aliased_bank_mem.sv
`timescale 1ns/1ps
module aliased_bank_mem
   import ghostmem_pkg::*;
#(
   parameter int CPU_AW  = 16,
   parameter int BANK_AW = 8,
   parameter int DW      = 8,
   parameter int SEL_BIT = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPU_AW-1:0] addr_i,
   input  logic [DW-1:0]     wdata_i,
   input  logic              cs_n_i,
   input  logic              rd_n_i,
   input  logic              wr_n_i,
   output logic [DW-1:0]     rdata_o,
   output logic              ghost_o,
   output logic              conflict_o
);
   localparam int NBANK    = 2;
   localparam int GHOST_LO = BANK_AW;
   localparam int GHOST_HI = SEL_BIT - 1;

   generate
      if (SEL_BIT <= BANK_AW) begin : g_bad_split
         $error("aliased_bank_mem: select bit must sit above bank address");
      end
   endgenerate

   acc_kind_e     kind;
   logic          rd_go, wr_go, clash;
   logic [NBANK-1:0] bank_en;
   logic [DW-1:0] bank_rd [NBANK];
   logic          conflict_q;

   assign kind  = classify(cs_n_i, rd_n_i, wr_n_i);
   assign rd_go = (kind == ACC_READ);
   assign wr_go = (kind == ACC_WRITE);
   assign clash = (kind == ACC_CLASH);

   bank_select_decode #(.CPU_AW(CPU_AW), .SEL_BIT(SEL_BIT), .NBANK(NBANK)) u_dec (
      .addr    (addr_i),
      .bank_en (bank_en)
   );

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         bank_store #(.AW(BANK_AW), .DW(DW)) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (bank_en[b]),
            .rd    (rd_go),
            .wr    (wr_go),
            .addr  (addr_i[BANK_AW-1:0]),
            .wdata (wdata_i),
            .rdata (bank_rd[b])
         );
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      for (int b = 0; b < NBANK; b++) rdata_o = rdata_o | bank_rd[b];
   end

   assign ghost_o = |addr_i[GHOST_HI:GHOST_LO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) conflict_q <= 1'b0;
      else        conflict_q <= clash;
   end
   assign conflict_o = conflict_q;

   // R2: a selected access enables exactly one bank
   a_r2_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n_i |-> ($countones(bank_en) == 1));

   // R5: no read data outside a clean read
   a_r5_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_i || rd_n_i || !wr_n_i) |-> (rdata_o == '0));

   // R8: a clash is flagged on the next cycle
   a_r8_clash_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_i && !rd_n_i && !wr_n_i) |=> conflict_o);

   // R8: the flag only follows a clash
   a_r8_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
      conflict_o |-> $past(!cs_n_i && !rd_n_i && !wr_n_i));
endmodule

// File: tb/aliased_bank_mem_bench.sv
`timescale 1ns/1ps
module aliased_bank_mem_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [7:0]  rdata;
   logic        ghost, conflict;

   always #4 clk = ~clk;   // 125 MHz

   aliased_bank_mem u_aliased_bank_mem (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
      .cs_n_i(cs_n), .rd_n_i(rd_n), .wr_n_i(wr_n),
      .rdata_o(rdata), .ghost_o(ghost), .conflict_o(conflict)
   );

   typedef struct {
      logic [7:0] rdata;
      logic       ghost;
      logic       clash;
      string      req;
   } exp_t;

   exp_t       sb[$];
   logic [7:0] model [512];
   logic       prev_clash = 1'b0;
   int         total = 0, bad = 0;
   bit         done = 0;

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // driver: apply one bus cycle and push what the outputs must show
   task automatic drive(input logic [15:0] a, input logic [7:0] d,
                        input logic c, input logic r, input logic w, input string req);
      exp_t e;
      logic rgo, wgo;
      int   idx;
      @(posedge clk); #1;
      addr = a; wdata = d; cs_n = c; rd_n = r; wr_n = w;
      idx = {23'd0, a[15], a[7:0]};
      rgo = !c && !r && w;
      wgo = !c && !w && r;
      e.rdata = rgo ? model[idx] : 8'h00;
      e.ghost = |a[14:8];
      e.clash = prev_clash;
      e.req   = req;
      sb.push_back(e);
      if (wgo) model[idx] = d;
      prev_clash = !c && !r && !w;
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
      drive(a, d, 1'b0, 1'b1, 1'b0, req);
   endtask

   task automatic rd(input logic [15:0] a, input string req);
      drive(a, 8'h00, 1'b0, 1'b0, 1'b1, req);
   endtask

   // monitor: compare against the scoreboard between edges
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         chk(e.req, "rdata", rdata, e.rdata);
         chk("R4", "ghost", {7'd0, ghost}, {7'd0, e.ghost});
         chk("R8", "conflict", {7'd0, conflict}, {7'd0, e.clash});
      end
   end

   initial begin
      logic [6:0] pats [4];
      pats[0] = 7'h01; pats[1] = 7'h40; pats[2] = 7'h7F; pats[3] = 7'h55;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9", "conflict in reset", {7'd0, conflict}, 8'h00);
      chk("R9", "rdata in reset", rdata, 8'h00);
      @(posedge clk); #1;
      rst_n = 1'b1;

      // fill both banks, bank 1 complement of bank 0
      for (int i = 0; i < 256; i++) begin
         wr({1'b0, 7'h00, 8'(i)}, 8'(i), "R6");
         wr({1'b1, 7'h00, 8'(i)}, ~8'(i), "R6");
      end
      // read back all 512 base locations
      for (int i = 0; i < 256; i++) begin
         rd({1'b0, 7'h00, 8'(i)}, "R1");
         rd({1'b1, 7'h00, 8'(i)}, "R2");
      end
      // aliased reads with several middle-bit patterns
      for (int i = 0; i < 256; i += 17) begin
         for (int p = 0; p < 4; p++) begin
            rd({1'b0, pats[p], 8'(i)}, "R3");
            rd({1'b1, pats[p], 8'(i)}, "R3");
         end
      end
      // write through an alias, see it at the base
      wr({1'b1, 7'h2A, 8'h10}, 8'hC3, "R3");
      rd({1'b1, 7'h00, 8'h10}, "R3");
      rd({1'b0, 7'h00, 8'h10}, "R1");
      // deselected read and write
      drive(16'h0005, 8'h00, 1'b1, 1'b0, 1'b1, "R5");
      drive(16'h0005, 8'hEE, 1'b1, 1'b1, 1'b0, "R6");
      rd(16'h0005, "R6");
      drive(16'h0005, 8'h00, 1'b0, 1'b1, 1'b1, "R5");
      // repeated reads leave data
      repeat (3) rd(16'h8033, "R7");
      // clash with chip select: no write, flagged next cycle
      drive(16'h0040, 8'h99, 1'b0, 1'b0, 1'b0, "R8");
      rd(16'h0040, "R8");
      drive(16'h0040, 8'h00, 1'b1, 1'b1, 1'b1, "R8");
      // both strobes without chip select: no flag, no write
      drive(16'h0040, 8'h77, 1'b1, 1'b0, 1'b0, "R8");
      rd(16'h0040, "R8");
      // ghost flag while idle
      drive(16'h7F00, 8'h00, 1'b1, 1'b1, 1'b1, "R4");
      drive(16'h8000, 8'h00, 1'b1, 1'b1, 1'b1, "R4");
      @(posedge clk); @(negedge clk); #1;
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule